// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Controller

This block collects 32 interrupt inputs and presents them to a processor through two independent banks: a normal bank and a fast bank. Each input first passes through a shared conditioning stage. A per-source polarity bit either passes the input through or inverts it. A per-source latch-select bit then chooses one of two modes: level-following, or holding a rising edge until software acknowledges it. Each bank has its own enable mask, its own priority threshold and its own registered request line.

Software uses a 32-bit register port that accepts single-cycle read and write strobes. Read data is registered. A service routine runs as follows:

1. While the bank's masked status is nonzero, read the bank's current-source register. That register returns the index of the best pending enabled source.
2. Service that source.
3. Read the bank's acknowledge register to release the held edges.

Arbitration chooses the smallest priority value first. Among sources with the same priority value, the lowest index wins. A source whose priority value is greater than the bank's threshold is hidden from that bank.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, both enable masks, the latch-select word and all held edges are 0. The polarity word is all ones. Both thresholds are 0xF. Each current-source register reads 0. Both request lines are low.
- R2: Writing to bank offset 0x08 sets the enable bits where the write data has 1s. Writing to bank offset 0x0C clears the enable bits where the write data has 1s. Zero bits have no effect in either case. Reading 0x08 or 0x0C returns the mask.
- R3: Polarity word at 0x200: bit i = 1 passes input i through unchanged, and bit i = 0 inverts it.
- R4: With latch-select bit i = 0, bit i of the raw view (bank offset 0x04) follows the conditioned input i.
- R5: With latch-select bit i = 1 (word at 0x204), a rising edge of conditioned input i sets raw bit i. The bit stays set after the input falls.
- R6: A read of bank offset 0x28 returns 0. It clears the held edges of every source enabled in that bank at the moment of the read. Held edges of sources not enabled in that bank are kept. An edge arriving in the same cycle as the read is kept. Clearing latch-select bit i drops the held edge of source i.
- R7: Masked status (bank offset 0x00) bit i = raw bit i AND enable bit i AND (priority of source i ≤ bank threshold).
- R8: Current source (bank offset 0x20) returns the index of the masked-status bit with the smallest priority value. Ties go to the lowest index. It returns 0 when masked status is 0.
- R9: Bank offset 0x2C holds a 4-bit threshold in bits 3:0. Sources whose priority value exceeds the threshold do not appear in that bank's status or request.
- R10: Each bank's request output is high exactly when that bank's masked status was nonzero at the previous clock edge.
- R11: The normal bank is decoded at 0x000 and the fast bank at 0x100. The two banks have separate masks, thresholds and requests.
- R12: Source i's priority sits in bits 3:0 of the word at 0x300 + 4·i and reads back. Priorities reset to 0.
- R13: Read data appears on the clock after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt inputs, synchronous to clk |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_norm_o | output | 1 | Normal bank request, registered |
| irq_fast_o | output | 1 | Fast bank request, registered |

## Verification
The bench goes after these corner cases:

- **Sources with equal priority values.** A design that broke ties on the highest index would return the wrong source number.
- **Threshold set to exclude every pending source.** A design that filtered only the current-source result would still raise the request line.
- **Acknowledge read from the bank where the held source is not enabled.** A design that cleared every latch on any acknowledge would lose that edge.
- **Inverted polarity with a sticky source.** A wrong inversion sense would latch on the falling edge instead of the rising one.

Random traffic then mixes input toggles with every register write and read. Against that traffic, the bench checks the request lines every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Address bits 9:8 select which region a register access targets.
    typedef enum logic [1:0] {
        BLK_NORM = 2'd0,
        BLK_FAST = 2'd1,
        BLK_CFG  = 2'd2,
        BLK_PRIO = 2'd3
    } blk_e;

    // Word offsets (address bits 7:2) inside a bank region.
    localparam logic [5:0] W_STATUS = 6'h00;
    localparam logic [5:0] W_RAW    = 6'h01;
    localparam logic [5:0] W_EN_SET = 6'h02;
    localparam logic [5:0] W_EN_CLR = 6'h03;
    localparam logic [5:0] W_CUR    = 6'h08;
    localparam logic [5:0] W_ACK    = 6'h0A;
    localparam logic [5:0] W_THR    = 6'h0B;

    // Word offsets inside the shared configuration region.
    localparam logic [5:0] W_POL    = 6'h00;
    localparam logic [5:0] W_STICKY = 6'h01;

    localparam int unsigned BANK_CNT = 2;

endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] pol_i,
    input  logic [NSRC-1:0] sticky_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] held;
    } cond_st_t;

    cond_st_t        st_d, st_q;
    logic [NSRC-1:0] cond;
    logic [NSRC-1:0] rise;

    always_comb begin
        cond      = src_i ^ ~pol_i;
        rise      = cond & ~st_q.prev;
        st_d.prev = cond;
        // A new edge wins over a clear in the same cycle.
        st_d.held = ((st_q.held & ~clr_i) | rise) & sticky_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_pend
        assign pend_o[i] = sticky_i[i] ? (st_q.held[i] | rise[i]) : cond[i];
    end

    // R6
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.held & $past(clr_i) & ~$past(rise)) == '0));

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 4,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          pend_i,
    input  logic [NSRC-1:0]          en_i,
    input  logic [NSRC-1:0][PW-1:0]  prio_i,
    input  logic [PW-1:0]            thr_i,
    output logic [NSRC-1:0]          status_o,
    output logic [IW-1:0]            cur_o,
    output logic                     irq_o
);

    typedef struct packed {
        logic irq;
    } bank_st_t;

    bank_st_t      st_d, st_q;
    logic [PW-1:0] best_p;
    logic [IW-1:0] best_i;
    logic          found;

    for (genvar i = 0; i < NSRC; i++) begin : g_mask
        assign status_o[i] = pend_i[i] & en_i[i] & (prio_i[i] <= thr_i);
    end

    always_comb begin
        best_p = '1;
        best_i = '0;
        found  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (status_o[i] && (!found || (prio_i[i] < best_p))) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = IW'(i);
            end
        end
        cur_o    = best_i;
        st_d.irq = |status_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R8
    cur_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_o) |-> status_o[cur_o]);

    // R8
    cur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> (cur_o == '0));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_o) |=> irq_o);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |=> !irq_o);

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 4,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   src_i,
    input  logic [11:0]   bus_addr_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [31:0]   bus_wdata_i,
    output logic [31:0]   bus_rdata_o,
    output logic          irq_norm_o,
    output logic          irq_fast_o
);

    localparam int unsigned IW = $clog2(NSRC);
    localparam int unsigned NB = BANK_CNT;

    typedef struct packed {
        logic [NB-1:0][NSRC-1:0] en;
        logic [NB-1:0][PW-1:0]   thr;
        logic [NSRC-1:0]         pol;
        logic [NSRC-1:0]         sticky;
        logic [NSRC-1:0][PW-1:0] prio;
        logic [DW-1:0]           rdata;
    } regs_t;

    regs_t           r_d, r_q;
    blk_e            blk;
    logic [5:0]      word;
    logic            bsel;
    logic            in_range;
    logic            is_bank;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] status [NB];
    logic [IW-1:0]   cur    [NB];
    logic [NB-1:0]   irq;
    logic [DW-1:0]   rd_val;

    // Address decode.
    always_comb begin
        blk      = blk_e'(bus_addr_i[9:8]);
        word     = bus_addr_i[7:2];
        bsel     = bus_addr_i[8];
        in_range = (bus_addr_i[AW-1:10] == '0);
        is_bank  = in_range && !bus_addr_i[9];
    end

    // Acknowledge read: release held edges of sources enabled in that bank.
    always_comb begin
        clr = '0;
        if (bus_rd_i && is_bank && (word == W_ACK)) begin
            clr = r_q.en[bsel];
        end
    end

    intc_src_cond #(
        .NSRC (NSRC)
    ) i_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i[NSRC-1:0]),
        .pol_i    (r_q.pol),
        .sticky_i (r_q.sticky),
        .clr_i    (clr),
        .pend_o   (pend)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        intc_bank #(
            .NSRC (NSRC),
            .PW   (PW)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_i   (pend),
            .en_i     (r_q.en[b]),
            .prio_i   (r_q.prio),
            .thr_i    (r_q.thr[b]),
            .status_o (status[b]),
            .cur_o    (cur[b]),
            .irq_o    (irq[b])
        );
    end

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        if (in_range) begin
            unique case (blk)
                BLK_NORM, BLK_FAST: begin
                    case (word)
                        W_STATUS:           rd_val[NSRC-1:0] = status[bsel];
                        W_RAW:              rd_val[NSRC-1:0] = pend;
                        W_EN_SET, W_EN_CLR: rd_val[NSRC-1:0] = r_q.en[bsel];
                        W_CUR:              rd_val[IW-1:0]   = cur[bsel];
                        W_THR:              rd_val[PW-1:0]   = r_q.thr[bsel];
                        default:            rd_val           = '0;
                    endcase
                end
                BLK_CFG: begin
                    case (word)
                        W_POL:    rd_val[NSRC-1:0] = r_q.pol;
                        W_STICKY: rd_val[NSRC-1:0] = r_q.sticky;
                        default:  rd_val           = '0;
                    endcase
                end
                BLK_PRIO: begin
                    if (int'(word) < NSRC) begin
                        rd_val[PW-1:0] = r_q.prio[word[IW-1:0]];
                    end
                end
                default: rd_val = '0;
            endcase
        end
    end

    // Next-state computation.
    always_comb begin
        r_d = r_q;
        if (bus_rd_i) begin
            r_d.rdata = rd_val;
        end
        if (bus_wr_i && in_range) begin
            unique case (blk)
                BLK_NORM, BLK_FAST: begin
                    case (word)
                        W_EN_SET: r_d.en[bsel]  = r_q.en[bsel] | bus_wdata_i[NSRC-1:0];
                        W_EN_CLR: r_d.en[bsel]  = r_q.en[bsel] & ~bus_wdata_i[NSRC-1:0];
                        W_THR:    r_d.thr[bsel] = bus_wdata_i[PW-1:0];
                        default:  ;
                    endcase
                end
                BLK_CFG: begin
                    case (word)
                        W_POL:    r_d.pol    = bus_wdata_i[NSRC-1:0];
                        W_STICKY: r_d.sticky = bus_wdata_i[NSRC-1:0];
                        default:  ;
                    endcase
                end
                BLK_PRIO: begin
                    if (int'(word) < NSRC) begin
                        r_d.prio[word[IW-1:0]] = bus_wdata_i[PW-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en     <= '0;
            r_q.thr    <= '1;
            r_q.pol    <= '1;
            r_q.sticky <= '0;
            r_q.prio   <= '0;
            r_q.rdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata_o = r_q.rdata;
    assign irq_norm_o  = irq[0];
    assign irq_fast_o  = irq[1];

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R2
        en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && is_bank && (bsel == 1'(b)) && (word == W_EN_CLR))
            |=> ((r_q.en[b] & $past(bus_wdata_i[NSRC-1:0])) == '0));

        // R2
        en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && is_bank && (bsel == 1'(b)) && (word == W_EN_SET))
            |=> ((r_q.en[b] & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));
    end

    // R6
    ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && is_bank && (word == W_ACK)) |=> (bus_rdata_o == '0));

endmodule

// File: tb/test_intc_dual_bank.sv
`timescale 1ns/1ps
module test_intc_dual_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n, irq_f;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    always #4 clk = ~clk;

    intc_dual_bank i_intc_dual_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (bus_addr),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_norm_o  (irq_n),
        .irq_fast_o  (irq_f)
    );

    // Reference model state, built from the requirements.
    logic [31:0] m_en [2];
    logic [3:0]  m_thr [2];
    logic [31:0] m_pol, m_sticky, m_lat, m_prev;
    logic [3:0]  m_prio [32];
    logic        m_irq [2];
    logic [31:0] mp, mclr, mcond;

    function automatic logic [31:0] f_pend();
        logic [31:0] c;
        logic [31:0] r;
        c = src ^ ~m_pol;
        r = c & ~m_prev;
        return (m_sticky & (m_lat | r)) | (~m_sticky & c);
    endfunction

    function automatic logic [31:0] f_masked(int b, logic [31:0] p);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            m[i] = p[i] & m_en[b][i] & (m_prio[i] <= m_thr[b]);
        end
        return m;
    endfunction

    function automatic logic [31:0] f_cur(int b, logic [31:0] p);
        logic [31:0] m;
        int best;
        m = f_masked(b, p);
        best = -1;
        for (int i = 0; i < 32; i++) begin
            if (m[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        end
        return (best < 0) ? 32'd0 : 32'(best);
    endfunction

    function automatic logic [31:0] f_read(logic [11:0] a);
        logic [31:0] p;
        int b;
        int w;
        p = f_pend();
        b = int'(a[8]);
        w = int'(a[7:2]);
        if (a[11:10] != 2'b00) return 32'd0;
        if (!a[9]) begin
            case (w)
                0:       return f_masked(b, p);
                1:       return p;
                2, 3:    return m_en[b];
                8:       return f_cur(b, p);
                11:      return {28'd0, m_thr[b]};
                default: return 32'd0;
            endcase
        end
        if (!a[8]) begin
            if (w == 0) return m_pol;
            if (w == 1) return m_sticky;
            return 32'd0;
        end
        if (w < 32) return {28'd0, m_prio[w]};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                m_en[b]  = '0;
                m_thr[b] = 4'hF;
                m_irq[b] = 1'b0;
            end
            m_pol    = '1;
            m_sticky = '0;
            m_lat    = '0;
            m_prev   = '0;
            for (int i = 0; i < 32; i++) m_prio[i] = '0;
        end else begin
            mp = f_pend();
            m_irq[0] = |f_masked(0, mp);
            m_irq[1] = |f_masked(1, mp);
            mclr = '0;
            if (bus_rd && bus_addr[11:9] == 3'b000 && bus_addr[7:2] == 6'h0A)
                mclr = m_en[bus_addr[8]];
            mcond  = src ^ ~m_pol;
            m_lat  = ((m_lat & ~mclr) | (mcond & ~m_prev)) & m_sticky;
            m_prev = mcond;
            if (bus_wr && bus_addr[11:10] == 2'b00) begin
                if (!bus_addr[9]) begin
                    case (bus_addr[7:2])
                        6'h02: m_en[bus_addr[8]] = m_en[bus_addr[8]] | bus_wdata;
                        6'h03: m_en[bus_addr[8]] = m_en[bus_addr[8]] & ~bus_wdata;
                        6'h0B: m_thr[bus_addr[8]] = bus_wdata[3:0];
                        default: ;
                    endcase
                end else if (!bus_addr[8]) begin
                    if (bus_addr[7:2] == 6'h00) m_pol = bus_wdata;
                    if (bus_addr[7:2] == 6'h01) m_sticky = bus_wdata;
                end else if (bus_addr[7:2] < 6'd32) begin
                    m_prio[bus_addr[6:2]] = bus_wdata[3:0];
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_irq();
        chk("R10 normal request", {31'd0, irq_n}, {31'd0, m_irq[0]});
        chk("R10 fast request", {31'd0, irq_f}, {31'd0, m_irq[1]});
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        chk_irq();
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk_irq();
    endtask

    task automatic rd(string req, logic [11:0] a, output logic [31:0] d);
        logic [31:0] e;
        bus_addr = a;
        bus_rd   = 1'b1;
        e = f_read(a);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        chk(req, d, e);
        chk_irq();
    endtask

    // Read with an extra literal expectation.
    task automatic rdx(string req, logic [11:0] a, logic [31:0] lit);
        logic [31:0] d;
        rd(req, a, d);
        chk(req, d, lit);
    endtask

    function automatic logic [11:0] pick_addr();
        int unsigned s;
        logic [11:0] base;
        s = $urandom % 14;
        base = ($urandom % 2 == 0) ? 12'h000 : 12'h100;
        case (s)
            0:  return base | 12'h000;
            1:  return base | 12'h004;
            2:  return base | 12'h008;
            3:  return base | 12'h00C;
            4:  return base | 12'h020;
            5:  return base | 12'h028;
            6:  return base | 12'h02C;
            7:  return 12'h200;
            8:  return 12'h204;
            9:  return 12'h300 | 12'(($urandom % 32) * 4);
            10: return base | 12'h024;
            11: return 12'h3F0;
            12: return 12'h840;
            default: return base | 12'h020;
        endcase
    endfunction

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20511));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", {30'd0, irq_n, irq_f}, 32'd0);
        rdx("R1 enable normal", 12'h008, 32'd0);
        rdx("R1 enable fast", 12'h108, 32'd0);
        rdx("R1 polarity", 12'h200, 32'hFFFF_FFFF);
        rdx("R1 sticky", 12'h204, 32'd0);
        rdx("R1 thr normal", 12'h02C, 32'hF);
        rdx("R1 thr fast", 12'h12C, 32'hF);
        rdx("R1 current", 12'h020, 32'd0);

        // R2 set / clear semantics
        wr(12'h008, 32'h0000_00F0);
        rdx("R2 after set", 12'h008, 32'h0000_00F0);
        wr(12'h00C, 32'h0000_0030);
        rdx("R2 after clear", 12'h00C, 32'h0000_00C0);
        rdx("R11 fast mask untouched", 12'h108, 32'd0);

        // R4 level following, R7, R8, R10
        src = 32'h0000_0040;
        idle();
        rdx("R4 raw level", 12'h004, 32'h0000_0040);
        rdx("R7 masked", 12'h000, 32'h0000_0040);
        chk("R10 normal high", {31'd0, irq_n}, 32'd1);
        chk("R11 fast low", {31'd0, irq_f}, 32'd0);
        rdx("R8 current index", 12'h020, 32'd6);

        // R3 polarity
        wr(12'h200, 32'hFFFF_FFBF);
        rdx("R3 inverted high input", 12'h004, 32'd0);
        src = 32'd0;
        idle();
        rdx("R3 inverted low input", 12'h004, 32'h0000_0040);
        wr(12'h200, 32'hFFFF_FFFF);
        idle();

        // R5 sticky latch
        wr(12'h204, 32'h0000_0080);
        src = 32'h0000_0080;
        idle();
        src = 32'd0;
        idle();
        idle();
        rdx("R5 held after fall", 12'h004, 32'h0000_0080);
        rdx("R5 masked held", 12'h000, 32'h0000_0080);

        // R6 acknowledge
        rdx("R6 ack data", 12'h028, 32'd0);
        rdx("R6 cleared", 12'h004, 32'd0);
        src = 32'h0000_0080;
        idle();
        src = 32'd0;
        rdx("R6 other bank ack returns 0", 12'h128, 32'd0);
        rdx("R6 kept after other bank ack", 12'h004, 32'h0000_0080);
        rdx("R6 ack", 12'h028, 32'd0);
        rdx("R6 cleared again", 12'h004, 32'd0);
        wr(12'h204, 32'd0);

        // R8 / R12 arbitration order
        wr(12'h008, 32'h0000_0A00);
        src = 32'h0000_0A00;
        wr(12'h32C, 32'd1);
        wr(12'h324, 32'd2);
        rdx("R8 smaller priority value wins", 12'h020, 32'd11);
        wr(12'h324, 32'd1);
        rdx("R8 tie lowest index", 12'h020, 32'd9);
        rdx("R12 priority readback", 12'h324, 32'd1);

        // R9 threshold
        wr(12'h02C, 32'd0);
        rdx("R9 masked filtered", 12'h000, 32'd0);
        chk("R9 request filtered", {31'd0, irq_n}, 32'd0);
        rdx("R8 idle current", 12'h020, 32'd0);
        wr(12'h02C, 32'hF);

        // R11 fast bank
        wr(12'h108, 32'h0000_0800);
        rdx("R11 fast masked", 12'h100, 32'h0000_0800);
        chk("R11 fast request", {31'd0, irq_f}, 32'd1);

        // R13 unmapped
        rdx("R13 hole in bank", 12'h024, 32'd0);
        rdx("R13 out of range", 12'h800, 32'd0);

        // Random traffic
        for (int k = 0; k < 5000; k++) begin
            int unsigned op;
            op = $urandom % 9;
            case (op)
                0, 1: begin
                    src = src ^ ($urandom & $urandom & $urandom);
                    idle();
                end
                2: wr((($urandom % 2) != 0) ? 12'h108 : 12'h008, $urandom & $urandom);
                3: wr((($urandom % 2) != 0) ? 12'h10C : 12'h00C, $urandom & $urandom);
                4: begin
                    case ($urandom % 4)
                        0: wr((($urandom % 2) != 0) ? 12'h12C : 12'h02C, $urandom % 16);
                        1: wr(12'h200, ~($urandom & $urandom));
                        2: wr(12'h204, $urandom);
                        default: wr(12'h300 | 12'(($urandom % 32) * 4), $urandom);
                    endcase
                end
                default: rd("R13 random read", pick_addr(), d);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule